// File: doc/BRIEF.md
# I/Q Offset Calibration Averager

This block removes a static DC offset from two 10-bit converter channels, I and Q, after the converter has been sampled. A rising edge on the calibrate request starts a fixed 34-cycle sequence. During that sequence the inputs are assumed to carry a zero differential signal. The block sums 32 samples from each channel, averages them and stores the average's distance from mid-scale as that channel's offset.

Outside the sequence, each incoming sample has its channel's stored offset subtracted. The result is clipped to the code range and registered. Because the correction happens after conversion, a nonzero offset shrinks the usable output range, and corrected values saturate at 0 or 1023. A stored offset stays in use until the next calibrate request. No recalibration happens on its own.

Top module: `iqoc_top`

## Requirements
- R1: A calibration starts only when `cal_req` is sampled high on a clock edge after having been sampled low on the edge before. Holding `cal_req` high does not start a second sequence.
- R2: `busy` rises on the clock edge that samples the start condition and stays high for exactly 34 clock cycles.
- R3: The samples accumulated are those presented before busy clock edges 2 through 33, counting the start edge as 0. That is exactly 32 samples per channel.
- R4: Each channel's offset is stored as (sum of its own 32 samples >> 5) - 512, a signed value. The I and Q offsets are computed independently.
- R5: While not busy, each output is registered one clock after its sample as sample - offset, clipped to the range 0..1023. Output codes are straight binary.
- R6: While `busy` is high, `i_out` and `q_out` hold the value they had when the sequence started.
- R7: After reset, `busy` is 0, both outputs are 0 and both offsets are 0, so samples pass through unchanged.
- R8: A rising edge on `cal_req` while `busy` is high is ignored and does not lengthen the sequence.
- R9: A stored offset stays in effect, unchanged, until the next calibration completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibrate request; its rising edge starts a sequence |
| i_sample | input | 10 | I channel converter code |
| q_sample | input | 10 | Q channel converter code |
| busy | output | 1 | High during the 34-cycle calibration sequence |
| i_out | output | 10 | Corrected I code |
| q_out | output | 10 | Corrected Q code |

## Verification
The assertions check the following on every cycle:
- a start happens only with `cal_req` high and `busy` low;
- every busy run is exactly 34 cycles long;
- exactly 32 accumulate cycles come before each store;
- the calibration phases never overlap;
- the outputs stay frozen while busy.

The arithmetic can only be shown by the bench's scenarios, which compare against an independent scoreboard model: the averaged offset per channel, subtraction with clipping at both code limits, persistence of an offset across a long idle stretch, and a request edge arriving mid-sequence.

// File: rtl/iqoc_pkg.sv
package iqoc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_ACC   = 2'd2,
    ST_STORE = 2'd3
  } cal_state_e;

  // Averaged sum relative to mid-scale
  function automatic int avg_offset(input int sum, input int shift, input int mid);
    return (sum >>> shift) - mid;
  endfunction

  // Subtract offset and clip to 0..maxv
  function automatic int sat_sub(input int smp, input int off, input int maxv);
    int d;
    d = smp - off;
    if (d < 0) return 0;
    if (d > maxv) return maxv;
    return d;
  endfunction

endpackage

// File: rtl/iqoc_edge.sv
module iqoc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  output logic start
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign start = req & ~req_q & ~busy;
endmodule

// File: rtl/iqoc_seq.sv
module iqoc_seq #(
  parameter int NSAMP = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic clr_en,
  output logic acc_en,
  output logic store_en,
  output logic busy
);
  import iqoc_pkg::*;

  localparam int CW = $clog2(NSAMP);

  cal_state_e      state;
  logic [CW-1:0]   cnt;
  logic            last_acc;

  assign last_acc = (cnt == CW'(NSAMP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (start) state <= ST_CLEAR;
        ST_CLEAR: begin
          state <= ST_ACC;
          cnt   <= '0;
        end
        ST_ACC: begin
          cnt <= cnt + 1'b1;
          if (last_acc) state <= ST_STORE;
        end
        ST_STORE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign clr_en   = (state == ST_CLEAR);
  assign acc_en   = (state == ST_ACC);
  assign store_en = (state == ST_STORE);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/iqoc_chan.sv
module iqoc_chan #(
  parameter int W     = 10,
  parameter int NSAMP = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic         acc_en,
  input  logic         store_en,
  input  logic         busy,
  input  logic [W-1:0] sample,
  output logic [W-1:0] corr
);
  import iqoc_pkg::*;

  localparam int SHIFT = $clog2(NSAMP);
  localparam int SW    = W + SHIFT;
  localparam int OW    = W + 1;
  localparam int MID   = 1 << (W - 1);
  localparam int MAXC  = (1 << W) - 1;

  logic [SW-1:0]        acc;
  logic signed [OW-1:0] offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      offset <= '0;
      corr   <= '0;
    end else begin
      if (clr_en)      acc <= '0;
      else if (acc_en) acc <= acc + SW'(sample);
      if (store_en)
        offset <= OW'(avg_offset(int'(acc), SHIFT, MID));
      if (!busy)
        corr <= W'(sat_sub(int'(sample), int'(offset), MAXC));
    end
  end
endmodule

// File: rtl/iqoc_top.sv
module iqoc_top #(
  parameter int W     = 10,
  parameter int NSAMP = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cal_req,
  input  logic [W-1:0] i_sample,
  input  logic [W-1:0] q_sample,
  output logic         busy,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out
);
  localparam int NCH = 2;

  logic start_pulse;
  logic clr_en;
  logic acc_en;
  logic store_en;

  logic [W-1:0] samp_a [NCH];
  logic [W-1:0] corr_a [NCH];

  assign samp_a[0] = i_sample;
  assign samp_a[1] = q_sample;
  assign i_out     = corr_a[0];
  assign q_out     = corr_a[1];

  iqoc_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cal_req),
    .busy  (busy),
    .start (start_pulse)
  );

  iqoc_seq #(.NSAMP(NSAMP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_pulse),
    .clr_en   (clr_en),
    .acc_en   (acc_en),
    .store_en (store_en),
    .busy     (busy)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iqoc_chan #(.W(W), .NSAMP(NSAMP)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (clr_en),
      .acc_en   (acc_en),
      .store_en (store_en),
      .busy     (busy),
      .sample   (samp_a[c]),
      .corr     (corr_a[c])
    );
  end
endmodule

// File: rtl/iqoc_chk.sv
module iqoc_chk #(
  parameter int W     = 10,
  parameter int NSAMP = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cal_req,
  input logic         busy,
  input logic         start_pulse,
  input logic         clr_en,
  input logic         acc_en,
  input logic         store_en,
  input logic [W-1:0] i_out,
  input logic [W-1:0] q_out
);
  localparam int RUN = NSAMP + 2;
  localparam int RW  = $clog2(RUN + 2) + 1;

  logic [RW-1:0] run_len;
  logic [RW-1:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      acc_cnt <= '0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (clr_en)      acc_cnt <= '0;
      else if (acc_en) acc_cnt <= acc_cnt + 1'b1;
    end
  end

  // R1
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (cal_req && !busy));

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (busy && clr_en));

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RW'(RUN)));

  // R3
  acc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> (acc_cnt == RW'(NSAMP)));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_en, acc_en, store_en}));

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(i_out) && $stable(q_out)));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !store_en) |=> busy);
endmodule

bind iqoc_top iqoc_chk #(.W(W), .NSAMP(NSAMP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cal_req     (cal_req),
  .busy        (busy),
  .start_pulse (start_pulse),
  .clr_en      (clr_en),
  .acc_en      (acc_en),
  .store_en    (store_en),
  .i_out       (i_out),
  .q_out       (q_out)
);

// File: tb/iqoc_top_test.sv
module iqoc_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cal_req;
  logic [9:0] i_in, q_in;
  logic       busy;
  logic [9:0] i_out, q_out;

  int checks = 0;
  int fails  = 0;
  int off_i = 0, off_q = 0;
  int last_i = 0, last_q = 0;

  typedef struct {
    int    ei;
    int    eq;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iqoc_top uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_req  (cal_req),
    .i_sample (i_in),
    .q_sample (q_in),
    .busy     (busy),
    .i_out    (i_out),
    .q_out    (q_out)
  );

  function automatic int clip(input int v);
    if (v < 0)    return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: one scoreboard item per clock edge
  always @(posedge clk) begin
    exp_t it;
    #1;
    if (sb.size() != 0) begin
      it = sb.pop_front();
      chk(i_out === 10'(it.ei), {it.tag, " i_out"}, int'(i_out), it.ei);
      chk(q_out === 10'(it.eq), {it.tag, " q_out"}, int'(q_out), it.eq);
    end
  end

  // Driver: one cycle of stimulus plus its expected result
  task automatic tick(input int si, input int sq, input bit req,
                      input bit hold, input bit exp_busy, input string tag);
    exp_t it;
    @(negedge clk);
    i_in = 10'(si); q_in = 10'(sq); cal_req = req;
    if (!hold) begin
      last_i = clip(si - off_i);
      last_q = clip(sq - off_q);
    end
    it.ei = last_i; it.eq = last_q; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #2;
    chk(busy === exp_busy, {tag, " busy"}, int'(busy), int'(exp_busy));
  endtask

  task automatic calibrate(input int bi, input int bq, input int di,
                           input int dq, input bit poke);
    int sum_i = 0, sum_q = 0;
    tick(100, 200, 1'b1, 1'b0, 1'b1, "R1 start edge");
    tick(1023, 0, 1'b1, 1'b1, 1'b1, "R6 hold first busy");
    for (int k = 0; k < 32; k++) begin
      int si, sq;
      bit r;
      si = clip(bi + ((k % 5) - 2) * di);
      sq = clip(bq + ((k % 3) - 1) * dq);
      sum_i += si; sum_q += sq;
      r = !(poke && k == 10);
      tick(si, sq, r, 1'b1, 1'b1, (poke && k == 11) ? "R8 edge while busy" : "R3 accumulate");
    end
    tick(0, 1023, 1'b1, 1'b1, 1'b0, "R2 busy ends at 34");
    off_i = (sum_i >> 5) - 512;
    off_q = (sum_q >> 5) - 512;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cal_req = 1'b0; i_in = '0; q_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R7 reset busy", int'(busy), 0);
    chk(i_out === 10'd0, "R7 reset i_out", int'(i_out), 0);
    chk(q_out === 10'd0, "R7 reset q_out", int'(q_out), 0);
    rst_n = 1'b1;

    // R7: pass-through with zero offsets
    tick(0, 1023, 1'b0, 1'b0, 1'b0, "R7 passthru");
    tick(777, 33, 1'b0, 1'b0, 1'b0, "R7 passthru");
    tick(512, 511, 1'b0, 1'b0, 1'b0, "R7 passthru");

    // R3 R4: distinct per-channel offsets
    calibrate(530, 490, 3, 5, 1'b0);
    // R1: level still high, no restart
    tick(600, 600, 1'b1, 1'b0, 1'b0, "R1 level no restart");
    tick(601, 602, 1'b1, 1'b0, 1'b0, "R1 level no restart");
    // R5: clipping at both limits, straight subtraction
    tick(1023, 1023, 1'b0, 1'b0, 1'b0, "R5 clip high");
    tick(5, 5, 1'b0, 1'b0, 1'b0, "R5 clip low");
    tick(512, 512, 1'b0, 1'b0, 1'b0, "R4 R5 mid");
    tick(300, 700, 1'b0, 1'b0, 1'b0, "R5 subtract");

    // R8: second calibration with a request edge mid-sequence
    calibrate(512, 600, 0, 2, 1'b1);
    tick(400, 400, 1'b0, 1'b0, 1'b0, "R4 R5 new offsets");

    // R9: offsets persist over a long idle stretch
    for (int n = 0; n < 60; n++)
      tick((n * 17) % 1024, (n * 29) % 1024, 1'b0, 1'b0, 1'b0, "R9 persist");

    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule